// File: doc/BRIEF.md
# Ripple-Carry Integer ALU

A purely combinational integer arithmetic logic unit that chains identical one-bit slices into a word-wide datapath. Two operands and a three-bit function code enter, and a result word comes out together with a zero flag, a signed-overflow flag and the adder's final carry. There is no state and no clock. The result settles after the carry has rippled through every slice.

Each slice holds a full adder and a four-way selector. The selector chooses between the bitwise AND, the bitwise OR, the adder sum, and a "less" input. The upper bit of the function code inverts operand B inside every slice and also feeds the carry into the lowest slice. Subtraction is therefore A + ~B + 1. For the compare operation, the sum bit of the most significant slice is returned through the less input of slice 0. The less inputs of all other slices are tied to zero.

The block is meant to sit in the execute stage of a simple integer pipeline. There, the result feeds writeback and the zero flag drives branch-on-equal decisions.

Top module: `ripple_alu`

## Requirements
- R1: Function code 000 returns A AND B, and code 001 returns A OR B, bit by bit.
- R2: Function code 010 returns (A + B) modulo 2^WIDTH. The carry flag is bit WIDTH of the unsigned sum.
- R3: Function code 110 returns A + ~B + 1 modulo 2^WIDTH. The carry flag is the carry out of that sum, so equal operands give result 0 with carry 1.
- R4: Function code 111 returns, in result bit 0, the most significant bit of A + ~B + 1, with all upper result bits 0. No overflow correction is applied, so A = most-negative and B = most-positive gives 0.
- R5: For every defined function code, the zero flag is 1 exactly when all result bits are 0.
- R6: The overflow flag is 1 when the two addends seen by the adder share a sign and the sum's sign differs from it. For codes 000, 001 and 010 the adder computes A + B. For codes 110 and 111 it computes A + ~B + 1. Carry and overflow follow the same adder for each code.
- R7: The undefined function codes 011, 100 and 101 return result 0 with the zero, overflow and carry flags all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 3 | Function code |
| result_o | output | WIDTH | Selected result word |
| zero_o | output | 1 | Result is all zeros (defined codes only) |
| overflow_o | output | 1 | Signed overflow of the adder |
| carry_o | output | 1 | Carry out of the top slice |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle its operands are applied, with no register in between. The bench changes the operands just after a rising clock edge and compares all four outputs at the following falling edge. The whole carry ripple therefore has half a period to settle, and no comparison shares a timestep with an input change. A four-bit copy of the block is swept over every operand pair and every function code. The 32-bit instance receives the sign-boundary and equal-operand pairs plus a stream of pseudo-random words.

// File: rtl/alu_pkg.sv
// Package: shared encodings for the ripple ALU.
// Assumes a fixed three-bit function code; the datapath width is set by
// the top module parameter.
package alu_pkg;

    localparam int OP_W = 3;

    // Function codes seen at the ALU boundary.
    typedef enum logic [OP_W-1:0] {
        FN_AND = 3'b000,
        FN_OR  = 3'b001,
        FN_ADD = 3'b010,
        FN_SUB = 3'b110,
        FN_SLT = 3'b111
    } alu_fn_e;

    // Per-slice output selector.
    typedef enum logic [1:0] {
        PICK_AND  = 2'd0,
        PICK_OR   = 2'd1,
        PICK_SUM  = 2'd2,
        PICK_LESS = 2'd3
    } slice_pick_e;

endpackage

// File: rtl/alu_op_decode.sv
// Module: alu_op_decode
// Turns the function code into slice controls. The upper code bit is the
// operand-B invert and low carry-in. Undefined codes clear the legal flag.
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output logic            legal_o,
    output logic            b_inv_o,
    output slice_pick_e     pick_o
);

    // Top code bit drives the B inversion for every code.
    assign b_inv_o = op_i[OP_W-1];

    // Map each defined code to a slice selection; flag the rest.
    always_comb begin
        legal_o = 1'b1;
        pick_o  = PICK_AND;
        case (op_i)
            FN_AND:  pick_o = PICK_AND;
            FN_OR:   pick_o = PICK_OR;
            FN_ADD:  pick_o = PICK_SUM;
            FN_SUB:  pick_o = PICK_SUM;
            FN_SLT:  pick_o = PICK_LESS;
            default: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_bit_slice.sv
// Module: alu_bit_slice
// One bit of the datapath: optional B inversion, full adder, and a
// four-way result selector. Assumes carry and less are wired by the parent.
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic        a_i,
    input  logic        b_i,
    input  logic        b_inv_i,
    input  logic        carry_i,
    input  logic        less_i,
    input  slice_pick_e pick_i,
    output logic        result_o,
    output logic        sum_o,
    output logic        carry_o
);

    logic b_eff;

    // Conditionally inverted B operand.
    assign b_eff = b_i ^ b_inv_i;

    // Full adder: sum and majority carry.
    assign sum_o   = a_i ^ b_eff ^ carry_i;
    assign carry_o = (a_i & b_eff) | (a_i & carry_i) | (b_eff & carry_i);

    // Result selector across the four slice sources.
    always_comb begin
        case (pick_i)
            PICK_AND:  result_o = a_i & b_eff;
            PICK_OR:   result_o = a_i | b_eff;
            PICK_SUM:  result_o = sum_o;
            default:   result_o = less_i;
        endcase
    end

endmodule

// File: rtl/alu_flag_gen.sv
// Module: alu_flag_gen
// Produces zero, overflow and carry flags from the gated result and the
// carries around the most significant slice. All flags clear when the
// function code is undefined.
module alu_flag_gen #(
    parameter int WIDTH = 32
) (
    input  logic             legal_i,
    input  logic [WIDTH-1:0] result_i,
    input  logic             msb_carry_in_i,
    input  logic             msb_carry_out_i,
    output logic             zero_o,
    output logic             overflow_o,
    output logic             carry_o
);

    // Zero detect over the whole word.
    assign zero_o     = legal_i & ~(|result_i);
    // Signed overflow from the carries entering and leaving the top slice.
    assign overflow_o = legal_i & (msb_carry_in_i ^ msb_carry_out_i);
    // Unsigned carry out of the chain.
    assign carry_o    = legal_i & msb_carry_out_i;

endmodule

// File: rtl/ripple_alu.sv
// Module: ripple_alu (top)
// Combinational WIDTH-bit ALU built from chained one-bit slices. Carries
// ripple slice to slice; the top slice's sum returns to slice 0's less
// input for the compare. Assumes WIDTH >= 2.
module ripple_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             overflow_o,
    output logic             carry_o
);

    localparam int MSB = WIDTH - 1;

    logic        legal;
    logic        b_inv;
    slice_pick_e pick;
    logic [WIDTH-1:0] raw_result;
    logic        msb_cin;
    logic        msb_cout;
    logic        msb_sum;

    alu_op_decode u_decode (
        .op_i    (op_i),
        .legal_o (legal),
        .b_inv_o (b_inv),
        .pick_o  (pick)
    );

    // Slice chain; per-slice scalars keep the ripple as discrete nets.
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic c_in;
        logic c_out;
        logic s;
        logic r;
        logic lss;

        if (i == 0) begin : g_lsb
            // Low slice: carry-in from the invert control, less from the top sum.
            assign c_in = b_inv;
            assign lss  = msb_sum;
        end else begin : g_upper
            // Upper slices: carry from the neighbour, less tied low.
            assign c_in = g_slice[i-1].c_out;
            assign lss  = 1'b0;
        end

        alu_bit_slice u_slice (
            .a_i      (a_i[i]),
            .b_i      (b_i[i]),
            .b_inv_i  (b_inv),
            .carry_i  (c_in),
            .less_i   (lss),
            .pick_i   (pick),
            .result_o (r),
            .sum_o    (s),
            .carry_o  (c_out)
        );

        // Collect the slice result into the word.
        assign raw_result[i] = r;
    end

    // Taps around the most significant slice.
    assign msb_cin  = g_slice[MSB].c_in;
    assign msb_cout = g_slice[MSB].c_out;
    assign msb_sum  = g_slice[MSB].s;

    // Undefined codes force the result to zero.
    assign result_o = legal ? raw_result : '0;

    alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .legal_i         (legal),
        .result_i        (result_o),
        .msb_carry_in_i  (msb_cin),
        .msb_carry_out_i (msb_cout),
        .zero_o          (zero_o),
        .overflow_o      (overflow_o),
        .carry_o         (carry_o)
    );

endmodule

// File: rtl/ripple_alu_chk.sv
// Module: ripple_alu_chk
// Port-level checks for ripple_alu, attached with bind. The block is
// combinational, so the checks are immediate assertions on settled values.
module ripple_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             overflow_o,
    input logic             carry_o
);

    logic [WIDTH:0] add_ext;
    logic [WIDTH:0] sub_ext;
    logic           is_defined;

    // Reference sums at one extra bit of width.
    assign add_ext    = {1'b0, a_i} + {1'b0, b_i};
    assign sub_ext    = {1'b0, a_i} + {1'b0, ~b_i} + 1'b1;
    assign is_defined = (op_i == 3'b000) || (op_i == 3'b001) || (op_i == 3'b010)
                     || (op_i == 3'b110) || (op_i == 3'b111);

    // Evaluate every check whenever the ports settle.
    always_comb begin
        // R1
        if (op_i == 3'b000) begin
            and_fn_chk: assert (result_o == (a_i & b_i));
        end
        // R2
        if (op_i == 3'b010) begin
            add_fn_chk: assert ({carry_o, result_o} == add_ext);
        end
        // R3
        if (op_i == 3'b110) begin
            sub_fn_chk: assert ({carry_o, result_o} == sub_ext);
        end
        // R4
        if (op_i == 3'b111) begin
            slt_fn_chk: assert (result_o == {{(WIDTH-1){1'b0}}, sub_ext[WIDTH-1]});
        end
        // R5
        if (is_defined) begin
            zero_flag_chk: assert (zero_o == (result_o == '0));
        end
        // R6
        if (op_i == 3'b010) begin
            add_ovf_chk: assert (overflow_o ==
                ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (result_o[WIDTH-1] != a_i[WIDTH-1])));
        end
        // R7
        if (!is_defined) begin
            undef_code_chk: assert (result_o == '0 && !zero_o && !overflow_o && !carry_o);
        end
    end

endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i        (a_i),
    .b_i        (b_i),
    .op_i       (op_i),
    .result_o   (result_o),
    .zero_o     (zero_o),
    .overflow_o (overflow_o),
    .carry_o    (carry_o)
);

// File: tb/ripple_alu_tb.sv
// Bench for ripple_alu: exhaustive sweep of a 4-bit copy, directed corners
// and pseudo-random words on the 32-bit instance.
module ripple_alu_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    // 100 MHz clock.
    always #5 clk = ~clk;

    logic [31:0] a32, b32, r32;
    logic [2:0]  op32;
    logic        z32, v32, c32;
    logic [3:0]  a4, b4, r4;
    logic [2:0]  op4;
    logic        z4, v4, c4;

    ripple_alu #(.WIDTH(32)) u_dut (
        .a_i(a32), .b_i(b32), .op_i(op32),
        .result_o(r32), .zero_o(z32), .overflow_o(v32), .carry_o(c32)
    );

    ripple_alu #(.WIDTH(4)) u_small (
        .a_i(a4), .b_i(b4), .op_i(op4),
        .result_o(r4), .zero_o(z4), .overflow_o(v4), .carry_o(c4)
    );

    // Expected {zero, overflow, carry, result} for an n-bit ALU.
    function automatic logic [34:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [2:0] op, input int n);
        logic [63:0] mask;
        logic [63:0] bb;
        logic [63:0] sum;
        logic [31:0] res;
        logic        ci, cy, ov, sa, sb, ss;
        mask = (64'd1 << n) - 64'd1;
        ci   = (op == 3'b110) || (op == 3'b111);
        bb   = ci ? (~{32'd0, b} & mask) : ({32'd0, b} & mask);
        sum  = ({32'd0, a} & mask) + bb + {63'd0, ci};
        cy   = sum[n];
        sa   = a[n-1];
        sb   = bb[n-1];
        ss   = sum[n-1];
        ov   = (sa == sb) && (ss != sa);
        case (op)
            3'b000:  res = a & b;
            3'b001:  res = a | b;
            3'b010:  res = sum[31:0];
            3'b110:  res = sum[31:0];
            3'b111:  res = {31'd0, ss};
            default: return 35'd0;
        endcase
        res = res & mask[31:0];
        return {res == 32'd0, ov, cy, res};
    endfunction

    // Requirement tag for a function code.
    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000, 3'b001: return "R1/R5/R6";
            3'b010:         return "R2/R5/R6";
            3'b110:         return "R3/R5/R6";
            3'b111:         return "R4/R5/R6";
            default:        return "R7";
        endcase
    endfunction

    // Compare one observed tuple against its expectation.
    task automatic check(input string req, input logic [34:0] got, input logic [34:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got z%0b v%0b c%0b r=%h expected z%0b v%0b c%0b r=%h",
                     req, got[34], got[33], got[32], got[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // Drive the 32-bit instance after a rising edge, compare at the falling edge.
    task automatic run32(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] op, input string req);
        @(posedge clk);
        #1;
        a32 = a; b32 = b; op32 = op;
        @(negedge clk);
        check(req, {z32, v32, c32, r32}, model(a, b, op, 32));
    endtask

    // xorshift step for pseudo-random operands.
    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        #1_500_000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    // Main stimulus sequence.
    initial begin
        logic [31:0] seed;
        a32 = '0; b32 = '0; op32 = 3'b000;
        a4 = '0; b4 = '0; op4 = 3'b000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: zero operands with AND give a zero result and zero flag set (R5).
        @(negedge clk);
        check("R5 idle", {z32, v32, c32, r32}, {1'b1, 1'b0, 1'b0, 32'd0});

        // Exhaustive 4-bit sweep over all codes and operand pairs.
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(posedge clk);
                    #1;
                    a4 = a[3:0]; b4 = b[3:0]; op4 = op[2:0];
                    @(negedge clk);
                    check(req_of(op[2:0]), {z4, v4, c4, 28'd0, r4},
                          model({28'd0, a[3:0]}, {28'd0, b[3:0]}, op[2:0], 4));
                end
            end
        end

        // R4: most-negative against most-positive gives 0 (no overflow correction).
        run32(32'h8000_0000, 32'h7FFF_FFFF, 3'b111, "R4 minint<maxint");
        check("R4 minint<maxint value", {z32, v32, c32, r32}, {1'b1, 1'b1, 1'b1, 32'd0});
        run32(32'h7FFF_FFFF, 32'h8000_0000, 3'b111, "R4 maxint<minint");
        run32(32'hFFFF_FFFF, 32'h0000_0001, 3'b111, "R4 -1<1");
        check("R4 -1<1 value", {z32, v32, c32, r32}, {1'b0, 1'b0, 1'b1, 32'd1});
        // R3: equal operands give zero with carry.
        run32(32'h1234_5678, 32'h1234_5678, 3'b110, "R3 equal");
        check("R3 equal value", {z32, v32, c32, r32}, {1'b1, 1'b0, 1'b1, 32'd0});
        run32(32'h8000_0000, 32'h0000_0001, 3'b110, "R3/R6 sub overflow");
        check("R6 sub overflow value", {z32, v32, c32, r32},
              {1'b0, 1'b1, 1'b1, 32'h7FFF_FFFF});
        // R2/R6: add overflow and wrap corners.
        run32(32'h7FFF_FFFF, 32'h0000_0001, 3'b010, "R2/R6 pos overflow");
        run32(32'h8000_0000, 32'h8000_0000, 3'b010, "R2/R6 neg overflow");
        run32(32'hFFFF_FFFF, 32'h0000_0001, 3'b010, "R2/R5 wrap");
        check("R2 wrap value", {z32, v32, c32, r32}, {1'b1, 1'b0, 1'b1, 32'd0});
        // R7: undefined codes with nonzero operands.
        run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, "R7 code 011");
        run32(32'h8000_0000, 32'h8000_0000, 3'b100, "R7 code 100");
        run32(32'hFFFF_FFFF, 32'h0000_0001, 3'b101, "R7 code 101");
        // R1: complementary patterns.
        run32(32'hA5A5_A5A5, 32'h5A5A_5A5A, 3'b000, "R1 and");
        run32(32'hA5A5_A5A5, 32'h5A5A_5A5A, 3'b001, "R1 or");

        // Pseudo-random words through every code.
        seed = 32'h1D87_2B41;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            seed = xs(seed); ra = seed;
            seed = xs(seed); rb = seed;
            if (k % 16 == 0) rb = ra;
            for (int op = 0; op < 8; op++) begin
                run32(ra, rb, op[2:0], req_of(op[2:0]));
            end
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule